// File: doc/BRIEF.md
# Level-2 Cache Maintenance Register Target

This block is the maintenance-control face of a level-2 cache controller, seen from a simple word-wide register bus. Software uses it to switch off write-back and line fill, to invalidate selected ways in the background, and to issue a sync that waits for that background work to finish. The block drives the cache array with two disable levels and with a one-hot per-way invalidate strobe. The tag and data arrays sit outside this block.

A flush follows this order. Software sets both disable bits. It writes a way mask to the invalidate register and polls that register until it reads zero. It then writes the sync register and polls its bit 0 until it clears. Last, it clears the disable bits. The invalidate register clears itself and serves as the completion flag. A sync is held behind any invalidation that is still in flight.

Requests are single-cycle and use `req_valid`/`req_ready`. Each accepted request gets exactly one response, one cycle later. The block uses only `req_addr[AW-1:2]` for decoding, so all registers are 32-bit words. `WAYS` must not exceed 32.

Top module: `l2_maint_regs`

## Requirements
- R1: After reset, `wb_disable`, `lf_disable`, `way_inv` and `rsp_valid` are 0, and every register reads 0.
- R2: The debug control word at byte offset 0x724 holds bit 0, which drives `wb_disable`, and bit 1, which drives `lf_disable`. Both bits read back. Its other bits read 0. Writing 0x3 sets both levels and writing 0x0 clears both.
- R3: A write to the invalidate register at offset 0x77C while it is idle loads `wdata[WAYS-1:0]` as the pending way mask. A read returns the pending mask and returns 0 once every selected way is done.
- R4: Pending ways are swept lowest index first. Each way takes `SWEEP_CYCLES` cycles. `way_inv` is one-hot on the way being swept, starting the cycle after the write is accepted. A way's mask bit clears at the end of its sweep.
- R5: A write of any value to the sync register at offset 0x730 sets its read bit 0 to 1. The bit returns to 0 only at a clock edge at which no way is pending, so it never clears before every earlier invalidation has finished.
- R6: A write to the invalidate register while a mask is pending does not change the mask. Such a write sets a sticky error flag, which reads as bit 0 of offset 0x738. Any write to 0x738 clears the flag.
- R7: Reads from unmapped offsets return 0. Writes to unmapped offsets change no register and no output.
- R8: `rsp_valid` is high exactly in the cycle after a request is accepted. For a read, `rsp_rdata` then carries the register value as it was at acceptance. `req_ready` is low only for a sync write that arrives while a sync is pending, and such a write is stalled until that sync finishes.
- R9: Writing mask 0 to an idle invalidate register starts no sweep and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request accepted one cycle earlier |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| wb_disable | output | 1 | Write-back disable level |
| lf_disable | output | 1 | Line-fill disable level |
| way_inv | output | WAYS | One-hot invalidate strobe for the way being swept |

## Verification
The hardest situation to reach is a second sync write arriving while the first sync is still held behind a long invalidation. Only in that case does the bus stall, and only then can the sync-versus-sweep ordering be watched cycle by cycle. The bench starts an all-ways invalidation and issues a sync right after it. It then sends a second sync and counts the cycles during which `req_ready` stays low. Finally it polls the invalidate mask down to zero and checks that the sync bit has cleared by the very next read.

// File: rtl/l2_maint_regs.sv
module l2_maint_regs #(
  parameter int WAYS         = 16,
  parameter int SWEEP_CYCLES = 64,
  parameter int AW           = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata,
  output logic            wb_disable,
  output logic            lf_disable,
  output logic [WAYS-1:0] way_inv
);
  localparam int CW = (SWEEP_CYCLES > 1) ? $clog2(SWEEP_CYCLES) : 1;
  localparam logic [AW-3:0] IDX_DBG  = (AW-2)'(32'h724 >> 2);
  localparam logic [AW-3:0] IDX_SYNC = (AW-2)'(32'h730 >> 2);
  localparam logic [AW-3:0] IDX_ERR  = (AW-2)'(32'h738 >> 2);
  localparam logic [AW-3:0] IDX_INV  = (AW-2)'(32'h77C >> 2);
  localparam logic [CW-1:0] CNT_LAST = CW'(SWEEP_CYCLES - 1);

  logic [1:0]      dbg_q;
  logic [WAYS-1:0] inv_mask;
  logic [CW-1:0]   cnt;
  logic            sync_pend;
  logic            err_q;
  logic            rsp_valid_q;
  logic [31:0]     rsp_rdata_q;
  logic [31:0]     rd_mux;

  wire [AW-3:0]   idx       = req_addr[AW-1:2];
  wire            hit_dbg   = idx == IDX_DBG;
  wire            hit_sync  = idx == IDX_SYNC;
  wire            hit_err   = idx == IDX_ERR;
  wire            hit_inv   = idx == IDX_INV;
  wire            inv_busy  = |inv_mask;
  wire [WAYS-1:0] cur_way   = inv_mask & (~inv_mask + WAYS'(1));
  wire            sweep_end = inv_busy && (cnt == CNT_LAST);

  assign req_ready = !(req_write && hit_sync && sync_pend);
  wire acc = req_valid && req_ready;
  wire wr  = acc && req_write;

  assign way_inv    = cur_way;
  assign wb_disable = dbg_q[0];
  assign lf_disable = dbg_q[1];
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;

  always_comb begin
    rd_mux = '0;
    if (hit_dbg)  rd_mux = {30'b0, dbg_q};
    if (hit_sync) rd_mux = {31'b0, sync_pend};
    if (hit_err)  rd_mux = {31'b0, err_q};
    if (hit_inv)  rd_mux = 32'(inv_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q       <= '0;
      inv_mask    <= '0;
      cnt         <= '0;
      sync_pend   <= 1'b0;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= acc;
      if (acc) rsp_rdata_q <= req_write ? 32'b0 : rd_mux;

      if (wr && hit_dbg) dbg_q <= req_wdata[1:0];

      if (wr && hit_inv && !inv_busy) begin
        inv_mask <= req_wdata[WAYS-1:0];
        cnt      <= '0;
      end else if (sweep_end) begin
        inv_mask <= inv_mask & ~cur_way;
        cnt      <= '0;
      end else if (inv_busy) begin
        cnt <= cnt + CW'(1);
      end

      if (wr && hit_inv && inv_busy) err_q <= 1'b1;
      else if (wr && hit_err)        err_q <= 1'b0;

      if (wr && hit_sync)  sync_pend <= 1'b1;
      else if (!inv_busy)  sync_pend <= 1'b0;
    end
  end
endmodule

module l2_maint_regs_chk #(
  parameter int WAYS = 16,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic [WAYS-1:0] way_inv,
  input logic [WAYS-1:0] inv_mask,
  input logic            sync_pend,
  input logic            err_q
);
  localparam logic [AW-3:0] IDX_SYNC = (AW-2)'(32'h730 >> 2);
  localparam logic [AW-3:0] IDX_ERR  = (AW-2)'(32'h738 >> 2);

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R8
  AST_STALL_ONLY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (req_write && sync_pend && req_addr[AW-1:2] == IDX_SYNC)); // R8
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_inv) && ((way_inv & ~inv_mask) == '0)); // R4
  AST_STROBE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_mask != '0) |-> (way_inv != '0)); // R4
  AST_MASK_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_mask != '0) |=> ((inv_mask & ~$past(inv_mask)) == '0)); // R6
  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pend && inv_mask != '0) |=> sync_pend); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(req_valid && req_ready && req_write && req_addr[AW-1:2] == IDX_ERR))
    |=> err_q); // R6
endmodule

bind l2_maint_regs l2_maint_regs_chk #(.WAYS(WAYS), .AW(AW)) u_chk (.*);

// File: tb/l2_maint_regs_bench.sv
module l2_maint_regs_bench;
  localparam int WAYS = 16;
  localparam int SW   = 8;
  localparam int AW   = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, wb_disable, lf_disable;
  logic [31:0] rsp_rdata;
  logic [WAYS-1:0] way_inv;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  l2_maint_regs #(.WAYS(WAYS), .SWEEP_CYCLES(SW), .AW(AW)) u_l2_maint_regs (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int stalls);
    stalls = 0;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; stalls++;
    end
    @(negedge clk);
    req_valid = 0;
    chk("R8 rsp_valid", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; int s;
    xfer(1'b1, a, d, rd, s);
  endtask

  task automatic rdchk(string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] rd; int s;
    xfer(1'b0, a, 32'h0, rd, s);
    chk(req, rd, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] rd; int s;
    rd = 1;
    while (rd != 0) xfer(1'b0, 12'h77C, 32'h0, rd, s);
  endtask

  task automatic t_reset();
    chk("R1 wb_disable", 32'(wb_disable), 0);
    chk("R1 lf_disable", 32'(lf_disable), 0);
    chk("R1 way_inv", 32'(way_inv), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    rdchk("R1 dbg", 12'h724, 0);
    rdchk("R1 inv", 12'h77C, 0);
    rdchk("R1 sync", 12'h730, 0);
    rdchk("R1 err", 12'h738, 0);
  endtask

  task automatic t_debug();
    wr(12'h724, 32'hFFFF_FFFF);
    rdchk("R2 dbg readback", 12'h724, 32'h3);
    chk("R2 wb level", 32'(wb_disable), 1);
    chk("R2 lf level", 32'(lf_disable), 1);
    wr(12'h724, 32'h2);
    chk("R2 wb only cleared", 32'({lf_disable, wb_disable}), 32'h2);
    wr(12'h724, 32'h0);
    chk("R2 both cleared", 32'({lf_disable, wb_disable}), 0);
  endtask

  task automatic t_sweep();
    wr(12'h77C, 32'h0000_0204);
    for (int k = 0; k <= 2 * SW; k++) begin
      logic [31:0] e;
      e = (k < SW) ? 32'h4 : (k < 2 * SW) ? 32'h200 : 32'h0;
      chk("R4 way_inv order", 32'(way_inv), e);
      @(negedge clk);
    end
    rdchk("R3 mask done", 12'h77C, 0);
    wr(12'h77C, 32'h0000_0081);
    rdchk("R3 mask pending", 12'h77C, 32'h81);
    wait_idle();
    chk("R3 idle strobe", 32'(way_inv), 0);
  endtask

  task automatic t_sync_order();
    logic [31:0] rd; int s;
    wr(12'h77C, 32'h0000_FFFF);
    wr(12'h730, 32'h0);
    rdchk("R5 sync pending", 12'h730, 1);
    xfer(1'b1, 12'h730, 32'h0, rd, s);
    nchk++;
    if (s < 2) begin
      nfail++;
      $display("FAIL R8 stall cycles actual=%0d expected>=2", s);
    end
    rd = 1;
    while (rd != 0) begin
      xfer(1'b0, 12'h77C, 32'h0, rd, s);
      if (rd != 0) begin
        logic [31:0] sp;
        xfer(1'b0, 12'h730, 32'h0, sp, s);
        chk("R5 sync held while ways pending", sp, 1);
      end
    end
    rdchk("R5 sync done after drain", 12'h730, 0);
    wr(12'h730, 32'h5);
    rdchk("R5 idle sync visible", 12'h730, 1);
    rdchk("R5 idle sync clears", 12'h730, 0);
  endtask

  task automatic t_error();
    wr(12'h77C, 32'h1);
    wr(12'h77C, 32'hF0);
    rdchk("R6 busy write ignored", 12'h77C, 32'h1);
    rdchk("R6 error set", 12'h738, 1);
    wait_idle();
    rdchk("R6 error sticky", 12'h738, 1);
    wr(12'h738, 32'h0);
    rdchk("R6 error cleared", 12'h738, 0);
  endtask

  task automatic t_unmapped();
    wr(12'h724, 32'h1);
    wr(12'h700, 32'hFFFF_FFFF);
    wr(12'h728, 32'h3);
    rdchk("R7 unmapped read", 12'h700, 0);
    rdchk("R7 unmapped read 2", 12'h728, 0);
    rdchk("R7 dbg untouched", 12'h724, 1);
    chk("R7 levels untouched", 32'({lf_disable, wb_disable}), 1);
    chk("R7 no strobe", 32'(way_inv), 0);
    wr(12'h724, 32'h0);
  endtask

  task automatic t_zero_mask();
    wr(12'h77C, 32'h0);
    chk("R9 no strobe", 32'(way_inv), 0);
    rdchk("R9 mask zero", 12'h77C, 0);
    rdchk("R9 no error", 12'h738, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_debug();
    t_sweep();
    t_sync_order();
    t_error();
    t_unmapped();
    t_zero_mask();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule